// File: doc/BRIEF.md
# Triple Frame Buffer Slot Arbiter

This block decides which of three frame-buffer slots a video writer fills and which one a video reader shows. The two sides run on unrelated pixel clocks and each tells the arbiter only that it has finished a frame. In return, each side receives a 2-bit slot index in its own clock domain. The arbiter guarantees that the two indices never point at the same slot. The pixel memory, sync generation and video timing all sit outside this block.

The write clock domain owns the arbitration state:

- the writer's slot;
- the slot holding the newest complete frame;
- a flag that says whether that frame has not yet been claimed;
- the arbiter's record of which slot the reader uses.

When the reader finishes a frame, it sends a request across a toggle synchronizer. The write domain answers with a grant toggle, which carries a slot index held stable while the grant crosses. The reader then returns an acknowledge toggle. When the input is faster than the output, unshown frames are overwritten. When the input is slower, the reader shows the same slot again.

Top module: `tripleSlotArbiter`

## Requirements
- R1: While `rstN` is low, and after it is released, the writer uses slot 0, the reader uses slot 1, and no frame counts as ready. A read completion before any write completion leaves the reader on slot 1.
- R2: A pulse on `wrDone` with no reader request in flight does two things. The slot just finished becomes the ready frame. The writer moves to the one slot that is neither the finished slot nor the reader's slot.
- R3: `wrSlot` and `rdSlot` are never equal at any time.
- R4: A pulse on `rdDone` while a ready frame exists that the reader has not yet taken moves `rdSlot` to that frame's slot.
- R5: A pulse on `rdDone` when no newer frame has completed since the reader's last switch leaves `rdSlot` unchanged, so the same frame is shown again.
- R6: If a second write completes before the reader takes the ready frame, that newer frame replaces the ready one. The older frame is never shown.
- R7: A `wrDone` pulse that arrives while a reader request is being granted or acknowledged is discarded. The writer keeps its slot and the ready frame does not change.
- R8: Slot indices on `wrSlot` and `rdSlot` only take the values 0, 1 and 2.
- R9: `wrSlot` changes only on the write clock edge that follows a `wrDone` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side pixel clock |
| rdClk | input | 1 | Read-side pixel clock, unrelated to wrClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrDone | input | 1 | One wrClk pulse when the writer completes a frame |
| rdDone | input | 1 | One rdClk pulse when the reader completes a frame |
| wrSlot | output | 2 | Slot the writer fills (wrClk domain) |
| rdSlot | output | 2 | Slot the reader shows (rdClk domain) |

## Verification
The assertions assume the following about the inputs:

- `wrDone` and `rdDone` are single-cycle pulses in their own domains.
- Reset is applied to both domains together.

The stimulus drives every pulse on the falling edge of its own clock and lets the handshake settle before the slots are compared. The only exception is the in-flight case: there, a write completion is placed deliberately inside the window between a reader request and its acknowledge, to exercise the discard path.

// File: rtl/fbArbPkg.sv
package fbArbPkg;
  localparam int SLOT_W = 2;
  typedef logic [SLOT_W-1:0] slotIdx_t;

  localparam slotIdx_t WR_RESET_SLOT = 2'd0;
  localparam slotIdx_t RD_RESET_SLOT = 2'd1;
  localparam slotIdx_t SPARE_RESET_SLOT = 2'd2;
  // Sum of all slot indices; the third slot is this minus the other two.
  localparam slotIdx_t SLOT_SUM = 2'd3;

  typedef struct packed {
    logic advance;  // writer finished, publish and move on
    logic drop;     // writer finished while a grant is in flight
    logic grant;    // answer a reader request
    logic ack;      // reader has applied the grant
  } wrStrobe_t;
endpackage

// File: rtl/fbToggleSync.sv
module fbToggleSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic togIn,
  output logic pulse
);
  localparam int LAST = STAGES;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[LAST-1:0], togIn};
  end

  assign pulse = chain[LAST] ^ chain[LAST-1];
endmodule

// File: rtl/slotCtrl.sv
module slotCtrl
  import fbArbPkg::*;
(
  input  logic       wrDone,
  input  logic       reqPulse,
  input  logic       ackPulse,
  input  logic       pending,
  output wrStrobe_t  strobe
);
  logic busy;

  always_comb begin
    busy           = pending | reqPulse;
    strobe.grant   = reqPulse;
    strobe.ack     = ackPulse;
    strobe.advance = wrDone & ~busy;
    strobe.drop    = wrDone & busy;
  end
endmodule

// File: rtl/slotPath.sv
module slotPath
  import fbArbPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  wrStrobe_t strobe,
  output slotIdx_t  wrSlot,
  output slotIdx_t  grantSlot,
  output logic      grantTog,
  output logic      pending
);
  slotIdx_t readySlot;
  slotIdx_t rdView;
  logic     fresh;
  slotIdx_t nextRd;

  assign nextRd = fresh ? readySlot : rdView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSlot    <= WR_RESET_SLOT;
      readySlot <= SPARE_RESET_SLOT;
      rdView    <= RD_RESET_SLOT;
      grantSlot <= RD_RESET_SLOT;
      fresh     <= 1'b0;
      grantTog  <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (strobe.advance) begin
        readySlot <= wrSlot;
        fresh     <= 1'b1;
        wrSlot    <= SLOT_SUM - rdView - wrSlot;
      end
      if (strobe.grant) begin
        grantSlot <= nextRd;
        rdView    <= nextRd;
        fresh     <= 1'b0;
        grantTog  <= ~grantTog;
        pending   <= 1'b1;
      end else if (strobe.ack) begin
        pending   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdSide.sv
module rdSide
  import fbArbPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdDone,
  input  logic     grantPulse,
  input  slotIdx_t grantSlot,
  output slotIdx_t rdSlot,
  output logic     reqTog,
  output logic     ackTog
);
  logic waiting;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSlot  <= RD_RESET_SLOT;
      reqTog  <= 1'b0;
      ackTog  <= 1'b0;
      waiting <= 1'b0;
    end else if (grantPulse) begin
      rdSlot  <= grantSlot;
      ackTog  <= ~ackTog;
      waiting <= 1'b0;
    end else if (rdDone && !waiting) begin
      reqTog  <= ~reqTog;
      waiting <= 1'b1;
    end
  end
endmodule

// File: rtl/tripleSlotArbiter.sv
module tripleSlotArbiter
  import fbArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       wrDone,
  input  logic       rdDone,
  output logic [1:0] wrSlot,
  output logic [1:0] rdSlot
);
  wrStrobe_t strobe;
  slotIdx_t  grantSlot;
  logic      grantTog, pending, reqTog, ackTog;
  logic      reqPulse, ackPulse, grantPulse;

  fbToggleSync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(wrClk), .rstN(rstN), .togIn(reqTog), .pulse(reqPulse));
  fbToggleSync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(wrClk), .rstN(rstN), .togIn(ackTog), .pulse(ackPulse));
  fbToggleSync #(.STAGES(SYNC_STAGES)) u_grantSync (
    .clk(rdClk), .rstN(rstN), .togIn(grantTog), .pulse(grantPulse));

  slotCtrl u_ctrl (
    .wrDone(wrDone), .reqPulse(reqPulse), .ackPulse(ackPulse),
    .pending(pending), .strobe(strobe));

  slotPath u_path (
    .clk(wrClk), .rstN(rstN), .strobe(strobe), .wrSlot(wrSlot),
    .grantSlot(grantSlot), .grantTog(grantTog), .pending(pending));

  rdSide u_rd (
    .clk(rdClk), .rstN(rstN), .rdDone(rdDone), .grantPulse(grantPulse),
    .grantSlot(grantSlot), .rdSlot(rdSlot), .reqTog(reqTog), .ackTog(ackTog));
endmodule

// File: rtl/fbArbChecker.sv
module fbArbChecker (
  input logic       wrClk,
  input logic       rdClk,
  input logic       rstN,
  input logic       wrDone,
  input logic [1:0] wrSlot,
  input logic [1:0] rdSlot
);
  assert_slots_differ_wr_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    wrSlot != rdSlot);
  assert_slots_differ_rd_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    rdSlot != wrSlot);
  assert_wr_in_range_R8: assert property (@(posedge wrClk) disable iff (!rstN)
    wrSlot != 2'd3);
  assert_rd_in_range_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    rdSlot != 2'd3);
  assert_wr_moves_on_done_R9: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrSlot != $past(wrSlot)) |-> $past(wrDone));
endmodule

bind tripleSlotArbiter fbArbChecker u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrDone(wrDone),
  .wrSlot(wrSlot), .rdSlot(rdSlot));

// File: tb/sim_tripleSlotArbiter.sv
`timescale 1ns/1ps
module sim_tripleSlotArbiter;
  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic wrDone = 1'b0, rdDone = 1'b0;
  logic [1:0] wrSlot, rdSlot;
  int checks = 0, fails = 0, clashes = 0, badIdx = 0;
  bit finished = 1'b0;

  always #10 wrClk = ~wrClk;   // 50 MHz
  always #13 rdClk = ~rdClk;   // unrelated read clock

  tripleSlotArbiter u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrDone(wrDone),
    .rdDone(rdDone), .wrSlot(wrSlot), .rdSlot(rdSlot));

  // {isRead, expected wrSlot, expected rdSlot}
  localparam logic [4:0] VEC [13] = '{
    5'b0_10_01, 5'b1_10_00, 5'b1_10_00, 5'b0_01_00, 5'b0_10_00,
    5'b1_10_01, 5'b0_00_01, 5'b1_00_10, 5'b1_00_10, 5'b0_01_10,
    5'b0_00_10, 5'b0_01_10, 5'b1_01_00};

  always @(negedge wrClk) if (rstN) begin
    if (wrSlot == rdSlot) clashes++;
    if (wrSlot == 2'd3 || rdSlot == 2'd3) badIdx++;
  end
  always @(negedge rdClk) if (rstN) begin
    if (wrSlot == rdSlot) clashes++;
    if (wrSlot == 2'd3 || rdSlot == 2'd3) badIdx++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseWr();
    @(negedge wrClk) wrDone = 1'b1;
    @(negedge wrClk) wrDone = 1'b0;
  endtask

  task automatic pulseRd();
    @(negedge rdClk) rdDone = 1'b1;
    @(negedge rdClk) rdDone = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge wrClk);
  endtask

  initial begin
    #105;
    check("R1 wrSlot in reset", wrSlot, 0);
    check("R1 rdSlot in reset", rdSlot, 1);
    rstN = 1'b1;
    settle();
    check("R1 wrSlot after release", wrSlot, 0);
    pulseRd(); settle();
    check("R1 nothing ready, reader stays", rdSlot, 1);

    for (int i = 0; i < 13; i++) begin
      if (VEC[i][4]) pulseRd(); else pulseWr();
      settle();
      check(VEC[i][4] ? "R9 wrSlot held on read" : "R2 writer advance",
            wrSlot, VEC[i][3:2]);
      check(VEC[i][4] ? ((i == 5) ? "R6 newest replaces stale" : "R4/R5 reader slot")
                      : "R2 reader unaffected", rdSlot, VEC[i][1:0]);
    end

    // R7: write completion lands while the reader request is in flight
    pulseRd();
    repeat (6) @(negedge wrClk);
    pulseWr();
    settle();
    check("R7 writer kept slot", wrSlot, 1);
    check("R7 reader repeats", rdSlot, 0);
    pulseRd(); settle();
    check("R7 discarded frame not ready", rdSlot, 0);

    check("R3 slot clashes seen", clashes, 0);
    check("R8 out-of-range indices seen", badIdx, 0);

    // Reset in the middle of operation
    pulseWr(); settle();
    #3 rstN = 1'b0;
    #20;
    check("R1 wrSlot mid-run reset", wrSlot, 0);
    check("R1 rdSlot mid-run reset", rdSlot, 1);
    #7 rstN = 1'b1;
    pulseRd(); settle();
    check("R1 ready cleared by reset", rdSlot, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wrClk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule